// File: doc/BRIEF.md
# Bar-Graph Staircase Frame Generator

This block is the controlling end of an analog bar-graph readout built from a serial 32-segment display loader. It generates the serial clock, the serial data, the enable, and a staircase code that feeds an external DAC or resistor ladder. An external comparator reports whether the measured input lies above the present staircase level. That single bit is the only input, and the block shifts it straight into the loader as segment data.

Each frame opens with a start bit of one and then sends one comparison bit per staircase step, for codes 0 to SEG_BITS-1. Three low padding bits follow, so the loader always receives a full set of 36 clocks and clears its shift register. The rising serial edge that shifts a bit into the loader also advances the staircase, which gives the comparator the next level. The comparator stays high while the input is above the ramp, so the lit segments form a contiguous bar.

The serial clock comes from the system clock through a divider with a 50% duty cycle. Data moves only on falling serial edges. An optional idle gap with enable low separates frames. The comparator bit passes through a configurable synchronizer before it is used.

Top module: `bargraph_frame_gen`

## Requirements
- R1: While the asynchronous active-low reset is asserted, at any time, the serial clock is 0, the serial data is 1 (start bit ready), the enable is 1 and the staircase code is 0. A frame begins as soon as reset is released.
- R2: Inside a frame, every high phase and every low phase of the serial clock lasts exactly HALF_DIV system clock cycles.
- R3: A frame contains exactly 1+SEG_BITS+PAD_BITS rising serial edges (36 by default), all with the enable high. The frame is followed by GAP_SLOTS serial periods in which the enable, the serial clock and the serial data are all low.
- R4: The bit captured at the first rising edge of each frame is 1.
- R5: The bits captured at rising edges 2 to SEG_BITS+1 are the comparator results for staircase codes 0 to SEG_BITS-1 in ascending order. With an input threshold T, where the comparator is high when T > code, bit c is 1 exactly when T > c.
- R6: The staircase code is 0 at frame start. While comparison bit c is being set up it equals c. It advances by one only on a rising serial edge, and it holds SEG_BITS-1 through the padding bits.
- R7: The PAD_BITS bits after the comparison bits are 0.
- R8: The serial data changes only while the serial clock is low, and it is stable for at least HALF_DIV system cycles before every rising serial edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_above_i | input | 1 | Comparator result: input above staircase level |
| ser_clk_o | output | 1 | Serial clock to the display loader |
| ser_data_o | output | 1 | Serial data to the display loader |
| ser_en_o | output | 1 | Data enable to the display loader, high during a frame |
| stair_code_o | output | STAIR_W | Staircase code to the DAC |

## Verification
The bench targets empty, single-segment, mid-scale, one-short-of-full, full and over-range thresholds. An off-by-one between the staircase step and the shifted bit would show up as a bar one segment too long or too short, or as a wrapped code in the padding. The bench also checks the data setup window before each rising edge and the exact count of 36 clocks. A design that updated data on the wrong edge, or dropped a padding clock, would break one of these checks and leave the loader uncleared. A reset in the middle of a frame checks that the sequence restarts cleanly with the start bit.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

   typedef enum logic [1:0] {
      SLOT_START = 2'd0,
      SLOT_CMP   = 2'd1,
      SLOT_PAD   = 2'd2,
      SLOT_IDLE  = 2'd3
   } slot_kind_e;

   // Classify a slot index within one frame period.
   function automatic slot_kind_e slot_kind(input int unsigned idx,
                                            input int unsigned seg,
                                            input int unsigned pad);
      if (idx == 0)         return SLOT_START;
      if (idx <= seg)       return SLOT_CMP;
      if (idx <= seg + pad) return SLOT_PAD;
      return SLOT_IDLE;
   endfunction

endpackage

// File: rtl/bgf_sclk_div.sv
module bgf_sclk_div #(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic rise_o,
   output logic fall_o
);

   logic tick;
   logic phase_q;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                cnt_q <= '0;
            else if (cnt_q == CNT_LAST) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == CNT_LAST);

         // R2: half periods longer than one cycle never tick back to back
         p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick |=> !tick);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   phase_q <= 1'b0;
      else if (tick) phase_q <= ~phase_q;
   end

   assign rise_o = tick & ~phase_q;
   assign fall_o = tick &  phase_q;

   // R2: rising and falling events alternate
   p_rise_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
   p_fall_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !fall_o);

endmodule

// File: rtl/bgf_sync.sv
module bgf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= (sh_q << 1) | STAGES'(d_i);
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bgf_sequencer.sv
module bgf_sequencer
   import bgf_pkg::*;
#(
   parameter int unsigned SEG_BITS  = 32,
   parameter int unsigned PAD_BITS  = 3,
   parameter int unsigned GAP_SLOTS = 1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        rise_i,
   input  logic                        fall_i,
   input  logic                        cmp_sync_i,
   output logic                        ser_clk_o,
   output logic                        ser_data_o,
   output logic                        ser_en_o,
   output logic [$clog2(SEG_BITS)-1:0] stair_o
);

   localparam int unsigned TOTAL   = 1 + SEG_BITS + PAD_BITS + GAP_SLOTS;
   localparam int unsigned SLOT_W  = $clog2(TOTAL);
   localparam int unsigned STAIR_W = $clog2(SEG_BITS);
   localparam logic [SLOT_W-1:0]  SLOT_LAST = SLOT_W'(TOTAL - 1);
   localparam logic [STAIR_W-1:0] STAIR_TOP = STAIR_W'(SEG_BITS - 1);

   logic [SLOT_W-1:0]  slot_q, slot_nx;
   logic [STAIR_W-1:0] stair_q;
   logic               sclk_q, sdata_q, en_q;
   slot_kind_e         kind_q, kind_nx;

   always_comb begin
      slot_nx = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      kind_q  = slot_kind(32'(slot_q),  SEG_BITS, PAD_BITS);
      kind_nx = slot_kind(32'(slot_nx), SEG_BITS, PAD_BITS);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q  <= '0;
         stair_q <= '0;
         sclk_q  <= 1'b0;
         sdata_q <= 1'b1;
         en_q    <= 1'b1;
      end else if (rise_i) begin
         // The edge that shifts this bit also steps the ramp.
         sclk_q <= (kind_q != SLOT_IDLE);
         if (kind_q == SLOT_CMP && stair_q != STAIR_TOP)
            stair_q <= stair_q + 1'b1;
      end else if (fall_i) begin
         sclk_q <= 1'b0;
         slot_q <= slot_nx;
         unique case (kind_nx)
            SLOT_START: begin sdata_q <= 1'b1;       en_q <= 1'b1; stair_q <= '0; end
            SLOT_CMP:   begin sdata_q <= cmp_sync_i; en_q <= 1'b1; end
            SLOT_PAD:   begin sdata_q <= 1'b0;       en_q <= 1'b1; end
            default:    begin sdata_q <= 1'b0;       en_q <= 1'b0; end
         endcase
      end
   end

   assign ser_clk_o  = sclk_q;
   assign ser_data_o = sdata_q;
   assign ser_en_o   = en_q;
   assign stair_o    = stair_q;

   // R8: data only moves while the serial clock is low
   p_data_clk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sdata_q) |-> !sclk_q);
   // R3: idle period keeps every loader line low
   p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |-> (!sclk_q && !sdata_q));
   // R3: no serial pulse outside a frame
   p_pulse_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sclk_q) |-> en_q);
   // R4: a frame opens with the start bit and a cleared ramp
   p_start_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q) |-> (sdata_q && stair_q == '0));
   // R6: the ramp either steps by one or restarts from zero
   p_stair_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(stair_q) |-> (stair_q == '0 || stair_q == $past(stair_q) + 1'b1));
   // R6: a nonzero ramp step coincides with a rising serial edge
   p_stair_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(stair_q) && stair_q != '0) |-> $rose(sclk_q));

endmodule

// File: rtl/bargraph_frame_gen.sv
module bargraph_frame_gen #(
   parameter int unsigned SEG_BITS    = 32,
   parameter int unsigned PAD_BITS    = 3,
   parameter int unsigned GAP_SLOTS   = 1,
   parameter int unsigned HALF_DIV    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned STAIR_W    = $clog2(SEG_BITS)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cmp_above_i,
   output logic               ser_clk_o,
   output logic               ser_data_o,
   output logic               ser_en_o,
   output logic [STAIR_W-1:0] stair_code_o
);

   generate
      if (SEG_BITS < 2) begin : g_bad_seg
         $error("SEG_BITS must be at least 2");
      end
      if (HALF_DIV <= SYNC_STAGES) begin : g_bad_div
         $error("HALF_DIV must exceed SYNC_STAGES so the comparator settles");
      end
   endgenerate

   logic rise, fall, cmp_sync;

   bgf_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_o (rise),
      .fall_o (fall)
   );

   bgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_above_i),
      .q_o    (cmp_sync)
   );

   bgf_sequencer #(
      .SEG_BITS  (SEG_BITS),
      .PAD_BITS  (PAD_BITS),
      .GAP_SLOTS (GAP_SLOTS)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .fall_i     (fall),
      .cmp_sync_i (cmp_sync),
      .ser_clk_o  (ser_clk_o),
      .ser_data_o (ser_data_o),
      .ser_en_o   (ser_en_o),
      .stair_o    (stair_code_o)
   );

endmodule

// File: tb/sim_bargraph_frame_gen.sv
`timescale 1ns/1ps
module sim_bargraph_frame_gen;

   localparam int SEG  = 32;
   localparam int PAD  = 3;
   localparam int HALF = 4;
   localparam int SW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp;
   logic sclk, sdata, en;
   logic [SW-1:0] stair;
   int thr_g = 0;

   always #2.5 clk = ~clk;

   // Comparator model: input above the staircase level.
   always_comb cmp = (thr_g > int'(stair));

   bargraph_frame_gen u0 (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cmp_above_i  (cmp),
      .ser_clk_o    (sclk),
      .ser_data_o   (sdata),
      .ser_en_o     (en),
      .stair_code_o (stair)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   bit prv_s = 1'b0, prv_d = 1'b1;
   logic [SW-1:0] prv_st = '0, st_before = '0;
   int since = 0, hi_len = 0, lo_len = 0, lo_at_rise = 0;
   bit rose_g, fell_g;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      rose_g    = sclk && !prv_s;
      fell_g    = !sclk && prv_s;
      st_before = prv_st;
      if (sdata !== prv_d) begin
         chk(sclk == 1'b0, "R8 data moved while serial clock high", int'(sclk), 0);
         since = 0;
      end else since++;
      if (rose_g) begin
         chk(since >= HALF, "R8 data setup before rising edge", since, HALF);
         lo_at_rise = lo_len;
         lo_len = 0;
      end
      if (fell_g) begin
         chk(hi_len == HALF, "R2 high phase length", hi_len, HALF);
         hi_len = 0;
      end
      if (sclk) hi_len++; else lo_len++;
      if (!en) chk(!sclk && !sdata, "R3 idle lines low", int'({sclk, sdata}), 0);
      prv_s  = sclk;
      prv_d  = sdata;
      prv_st = stair;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0,  "R1 reset serial clock", int'(sclk), 0);
      chk(sdata == 1'b1, "R1 reset serial data", int'(sdata), 1);
      chk(en == 1'b1,    "R1 reset enable", int'(en), 1);
      chk(stair == '0,   "R1 reset staircase", int'(stair), 0);
      rst_n  = 1'b1;
      prv_s  = 1'b0;
      prv_d  = 1'b1;
      prv_st = '0;
      since  = 0;
      hi_len = 0;
      lo_len = 0;
   endtask

   // One frame at threshold thr; checks start bit, bar, ramp, padding, count.
   task automatic do_frame(input int thr);
      int n = 0;
      int exp;
      thr_g = thr;
      while (en !== 1'b1) step();
      while (en === 1'b1) begin
         step();
         if (rose_g) begin
            chk(en == 1'b1, "R3 enable high at rising edge", int'(en), 1);
            if (n == 0) begin
               chk(sdata == 1'b1, "R4 start bit", int'(sdata), 1);
               chk(st_before == '0, "R6 staircase zero at frame start", int'(st_before), 0);
            end else if (n <= SEG) begin
               exp = (thr > n - 1) ? 1 : 0;
               chk(int'(sdata) == exp, $sformatf("R5 bar bit code %0d thr %0d", n - 1, thr),
                   int'(sdata), exp);
               chk(int'(st_before) == n - 1, "R6 staircase code for comparison bit",
                   int'(st_before), n - 1);
            end else begin
               chk(sdata == 1'b0, "R7 padding bit low", int'(sdata), 0);
               chk(int'(st_before) == SEG - 1, "R6 staircase holds through padding",
                   int'(st_before), SEG - 1);
            end
            if (n > 0) chk(lo_at_rise == HALF, "R2 low phase length", lo_at_rise, HALF);
            n++;
         end
      end
      chk(n == 1 + SEG + PAD, "R3 rising edges per frame", n, 1 + SEG + PAD);
   endtask

   task automatic reset_mid_frame();
      thr_g = 20;
      repeat (100) step();
      apply_reset();
      do_frame(20);
   endtask

   initial begin
      apply_reset();
      do_frame(0);
      do_frame(1);
      do_frame(13);
      do_frame(31);
      do_frame(32);
      do_frame(100);
      reset_mid_frame();
      do_frame(7);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule